// File: doc/BRIEF.md
# Mode-Gated Host Access Controller

This block sits between a host processor and a coprocessor and decides what the host may touch. The host drives a simple select/write-enable bus with a ready return. Each access is decoded into one of three targets: a control word, a dual-ported 40-bit shared memory, or the coprocessor's internal space, which holds registers and program storage. A single mode bit separates the two operating modes: system mode, used to load programs, and run mode, in which the coprocessor executes.

In system mode every target is open to the host. In run mode the internal space is closed. Writes to it are discarded and set a sticky error flag, and reads from it return zero. The shared memory and the control word stay reachable in both modes. The coprocessor has its own port on the shared memory and may use it in the same cycle as the host. The mode changes only when an access completes, so no transfer ever sees two different modes.

Top module: `mode_gate`

## Requirements
- R1: While rst_n is low and after its release, run_mode, err_flag, hready are 0 and hrdata is 0.
- R2: An access begins when hsel is high while no access is in progress. hready is high exactly in the following cycle, for one cycle. Read data is on hrdata in that cycle only, and hrdata is 0 in every other cycle. Address, data and write enable must be held until hready.
- R3: In system mode, addresses with haddr[15]=1 reach the internal space at word index haddr[7:0]. The space is 32 bits wide and can be both written and read.
- R4: Addresses with haddr[15:14]=01 reach the shared memory at word index haddr[10:1]. With haddr[0]=0 the access covers bits 31:0. With haddr[0]=1 it covers bits 39:32, which appear on hrdata[7:0] (upper bits 0) and are written from hwdata[7:0].
- R5: The control word is at address 0. A write sets the mode from hwdata[0] (1 = run), and a write with hwdata[1]=1 clears the error flag. A read returns mode in bit 0 and the error flag in bit 1, with the other bits 0.
- R6: run_mode changes only at the clock edge that completes a control-word write. It is therefore constant across every access.
- R7: In run mode, a write to the internal space is discarded and sets err_flag, which stays high until cleared through R5. A read of the internal space returns 0.
- R8: In run mode, the shared memory and the control word behave exactly as in system mode.
- R9: Addresses with haddr[15:14]=00, other than 0, read as 0. Writes to them have no effect and do not set the error flag.
- R10: Coprocessor port: with core_en high and core_wen high, the full 40-bit word is written at the edge. With core_en high and core_wen low, core_rdata shows the word one cycle later. This works in both modes.
- R11: When the host and the coprocessor write the same shared word at the same edge, the coprocessor's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Host access request |
| hwen | input | 1 | Host write enable |
| haddr | input | 16 | Host word address |
| hwdata | input | 32 | Host write data |
| hrdata | output | 32 | Host read data, valid with hready |
| hready | output | 1 | Access completes this cycle |
| run_mode | output | 1 | 1 = run mode, 0 = system mode |
| err_flag | output | 1 | Sticky flag for a blocked write |
| core_en | input | 1 | Coprocessor shared-memory enable |
| core_wen | input | 1 | Coprocessor write enable |
| core_addr | input | 10 | Coprocessor shared word index |
| core_wdata | input | 40 | Coprocessor write data |
| core_rdata | output | 40 | Coprocessor read data, one cycle after enable |

## Verification
A wrong mode or error bit shows on run_mode and err_flag at the next falling edge after the completing access. A wrong mode also shows in the data of the next internal-space read, which returns 0 or stored data. A stuck access phase shows in the very next cycle as a missing or doubled hready. A word that lands in the wrong place or half stays hidden until it is read back from the host or coprocessor port, so the bench reads back every location it writes.

// File: rtl/mode_gate_pkg.sv
package mode_gate_pkg;

    localparam int HDW = 32;

    typedef enum logic [1:0] {
        TGT_CTRL,
        TGT_SHARED,
        TGT_INNER,
        TGT_NONE
    } target_e;

    typedef struct packed {
        logic           busy;
        logic           mode;
        logic           err;
        logic [HDW-1:0] rdata;
    } gate_st_t;

endpackage

// File: rtl/mode_gate_decode.sv
module mode_gate_decode
    import mode_gate_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SH_AW = 10,
    parameter int IN_AW = 8
) (
    input  logic [AW-1:0]    addr,
    input  logic             run,
    output target_e          tgt,
    output logic             blocked,
    output logic [SH_AW-1:0] sh_idx,
    output logic             sh_hi,
    output logic [IN_AW-1:0] in_idx
);
    always_comb begin
        if (addr[AW-1]) begin
            tgt = TGT_INNER;
        end else if (addr[AW-2]) begin
            tgt = TGT_SHARED;
        end else if (addr[AW-3:0] == '0) begin
            tgt = TGT_CTRL;
        end else begin
            tgt = TGT_NONE;
        end
    end

    assign blocked = (tgt == TGT_INNER) && run;
    assign sh_idx  = addr[SH_AW:1];
    assign sh_hi   = addr[0];
    assign in_idx  = addr[IN_AW-1:0];
endmodule

// File: rtl/mode_gate_ram.sv
module mode_gate_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mode_gate_shmem.sv
module mode_gate_shmem #(
    parameter int SW    = 40,
    parameter int HDW   = 32,
    parameter int DEPTH = 1024,
    localparam int IW   = $clog2(DEPTH),
    localparam int HI_W = SW - HDW
) (
    input  logic           clk,
    input  logic           h_we_lo,
    input  logic           h_we_hi,
    input  logic [IW-1:0]  h_idx,
    input  logic [HDW-1:0] h_wdata,
    output logic [SW-1:0]  h_word,
    input  logic           c_en,
    input  logic           c_we,
    input  logic [IW-1:0]  c_idx,
    input  logic [SW-1:0]  c_wdata,
    output logic [SW-1:0]  c_rdata
);
    logic [SW-1:0] mem [DEPTH];

    // host first, core last: on a same-word collision the core's data stays
    always_ff @(posedge clk) begin
        if (h_we_lo) begin
            mem[h_idx][HDW-1:0] <= h_wdata;
        end
        if (h_we_hi) begin
            mem[h_idx][SW-1:HDW] <= h_wdata[HI_W-1:0];
        end
        if (c_en && c_we) begin
            mem[c_idx] <= c_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (c_en && !c_we) begin
            c_rdata <= mem[c_idx];
        end
    end

    assign h_word = mem[h_idx];
endmodule

// File: rtl/mode_gate.sv
module mode_gate
    import mode_gate_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SW       = 40,
    parameter int SH_DEPTH = 1024,
    parameter int IN_DEPTH = 256,
    localparam int SH_AW   = $clog2(SH_DEPTH),
    localparam int IN_AW   = $clog2(IN_DEPTH),
    localparam int HI_W    = SW - HDW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsel,
    input  logic             hwen,
    input  logic [AW-1:0]    haddr,
    input  logic [HDW-1:0]   hwdata,
    output logic [HDW-1:0]   hrdata,
    output logic             hready,
    output logic             run_mode,
    output logic             err_flag,
    input  logic             core_en,
    input  logic             core_wen,
    input  logic [SH_AW-1:0] core_addr,
    input  logic [SW-1:0]    core_wdata,
    output logic [SW-1:0]    core_rdata
);
    gate_st_t st_d, st_q;

    target_e          tgt;
    logic             blocked;
    logic [SH_AW-1:0] sh_idx;
    logic             sh_hi;
    logic [IN_AW-1:0] in_idx;
    logic [SW-1:0]    sh_word;
    logic [HDW-1:0]   in_word;
    logic             sh_we_lo, sh_we_hi, in_we;
    logic [HDW-1:0]   rd_val;

    mode_gate_decode #(.AW(AW), .SH_AW(SH_AW), .IN_AW(IN_AW)) i_decode (
        .addr    (haddr),
        .run     (st_q.mode),
        .tgt     (tgt),
        .blocked (blocked),
        .sh_idx  (sh_idx),
        .sh_hi   (sh_hi),
        .in_idx  (in_idx)
    );

    mode_gate_shmem #(.SW(SW), .HDW(HDW), .DEPTH(SH_DEPTH)) i_shmem (
        .clk     (clk),
        .h_we_lo (sh_we_lo),
        .h_we_hi (sh_we_hi),
        .h_idx   (sh_idx),
        .h_wdata (hwdata),
        .h_word  (sh_word),
        .c_en    (core_en),
        .c_we    (core_wen),
        .c_idx   (core_addr),
        .c_wdata (core_wdata),
        .c_rdata (core_rdata)
    );

    mode_gate_ram #(.DW(HDW), .DEPTH(IN_DEPTH)) i_inner (
        .clk   (clk),
        .we    (in_we),
        .idx   (in_idx),
        .wdata (hwdata),
        .rdata (in_word)
    );

    always_comb begin
        unique case (tgt)
            TGT_CTRL:   rd_val = {{(HDW-2){1'b0}}, st_q.err, st_q.mode};
            TGT_SHARED: rd_val = sh_hi ? {{(HDW-HI_W){1'b0}}, sh_word[SW-1:HDW]}
                                       : sh_word[HDW-1:0];
            TGT_INNER:  rd_val = blocked ? '0 : in_word;
            default:    rd_val = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        sh_we_lo = 1'b0;
        sh_we_hi = 1'b0;
        in_we    = 1'b0;
        if (!st_q.busy) begin
            // start phase: data is captured using the mode that holds for the whole access
            st_d.busy = hsel;
            if (hsel) begin
                st_d.rdata = rd_val;
            end
        end else begin
            // completion phase: writes and any mode change land on this edge
            st_d.busy  = 1'b0;
            st_d.rdata = '0;
            if (hwen) begin
                unique case (tgt)
                    TGT_CTRL: begin
                        st_d.mode = hwdata[0];
                        if (hwdata[1]) begin
                            st_d.err = 1'b0;
                        end
                    end
                    TGT_SHARED: begin
                        sh_we_lo = !sh_hi;
                        sh_we_hi = sh_hi;
                    end
                    TGT_INNER: begin
                        if (blocked) begin
                            st_d.err = 1'b1;
                        end else begin
                            in_we = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hready   = st_q.busy;
    assign hrdata   = st_q.rdata;
    assign run_mode = st_q.mode;
    assign err_flag = st_q.err;
endmodule

// File: rtl/mode_gate_chk.sv
module mode_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hsel,
    input logic        hwen,
    input logic [15:0] haddr,
    input logic [31:0] hwdata,
    input logic [31:0] hrdata,
    input logic        hready,
    input logic        run_mode,
    input logic        err_flag
);
    a_r2_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
        hready |=> !hready);

    a_r2_ready_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        hready |-> $past(hsel && !hready));

    a_r2_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> hrdata == '0);

    a_r6_mode_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode != $past(run_mode)) |-> $past(hready && hwen && haddr == 16'h0));

    a_r7_err_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(run_mode && hready && hwen && haddr[15]));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(hready && hwen && haddr == 16'h0 && hwdata[1]));
endmodule

bind mode_gate mode_gate_chk i_chk (.*);

// File: tb/test_mode_gate.sv
`timescale 1ns/1ps
module test_mode_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwen = 1'b0;
    logic [15:0] haddr = '0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready, run_mode, err_flag;
    logic        core_en = 1'b0, core_wen = 1'b0;
    logic [9:0]  core_addr = '0;
    logic [39:0] core_wdata = '0;
    logic [39:0] core_rdata;

    int vecs = 0, fails = 0;
    bit live = 0, done = 0;

    logic [39:0] m_sh [1024];
    logic [31:0] m_in [256];
    bit m_mode = 0, m_err = 0, m_busy = 0;

    always #2.5 clk = ~clk;

    mode_gate i_mode_gate (.*);

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (live) begin
            chk(hready === m_busy, "R2 hready", {63'b0, hready}, {63'b0, m_busy});
            chk(run_mode === m_mode, "R6 run_mode", {63'b0, run_mode}, {63'b0, m_mode});
            chk(err_flag === m_err, "R7 err_flag", {63'b0, err_flag}, {63'b0, m_err});
            if (!m_busy) chk(hrdata === 32'h0, "R2 idle hrdata", {32'b0, hrdata}, 64'h0);
        end
    end

    function automatic logic [31:0] model_rd(input logic [15:0] a);
        if (a[15]) return m_mode ? 32'h0 : m_in[a[7:0]];
        if (a[14]) return a[0] ? {24'h0, m_sh[a[10:1]][39:32]} : m_sh[a[10:1]][31:0];
        if (a == 16'h0) return {30'h0, m_err, m_mode};
        return 32'h0;
    endfunction

    task automatic model_wr(input logic [15:0] a, input logic [31:0] d);
        if (a[15]) begin
            if (m_mode) m_err = 1; else m_in[a[7:0]] = d;
        end else if (a[14]) begin
            if (a[0]) m_sh[a[10:1]][39:32] = d[7:0];
            else m_sh[a[10:1]][31:0] = d;
        end else if (a == 16'h0) begin
            m_mode = d[0];
            if (d[1]) m_err = 0;
        end
    endtask

    task automatic acc(input bit w, input logic [15:0] a, input logic [31:0] d, input string rq);
        logic [31:0] exp;
        @(negedge clk);
        hsel = 1; hwen = w; haddr = a; hwdata = d;
        exp = model_rd(a);
        @(posedge clk);
        m_busy = 1;
        @(negedge clk);
        chk(hready === 1'b1, rq, {63'b0, hready}, 64'h1);
        if (!w) chk(hrdata === exp, rq, {32'b0, hrdata}, {32'b0, exp});
        @(posedge clk);
        m_busy = 0;
        if (w) model_wr(a, d);
        @(negedge clk);
        hsel = 0; hwen = 0;
    endtask

    task automatic core_op(input bit w, input logic [9:0] i, input logic [39:0] d, input string rq);
        logic [39:0] exp;
        @(negedge clk);
        core_en = 1; core_wen = w; core_addr = i; core_wdata = d;
        exp = m_sh[i];
        @(posedge clk);
        if (w) m_sh[i] = d;
        @(negedge clk);
        core_en = 0; core_wen = 0;
        if (!w) chk(core_rdata === exp, rq, {24'b0, core_rdata}, {24'b0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(run_mode === 0 && err_flag === 0 && hready === 0 && hrdata === 0, "R1 in reset",
            {29'b0, run_mode, err_flag, hready, hrdata}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        chk(run_mode === 0 && err_flag === 0 && hready === 0 && hrdata === 0, "R1 after reset",
            {29'b0, run_mode, err_flag, hready, hrdata}, 64'h0);
        live = 1;

        // R3 internal space in system mode
        acc(1, 16'h8003, 32'hA5A5_1234, "R3 wr");
        acc(1, 16'h80FF, 32'h0BAD_F00D, "R3 wr top");
        acc(0, 16'h8003, 0, "R3 rd");
        acc(0, 16'h80FF, 0, "R3 rd top");
        // R4 shared memory halves, both ends
        acc(1, 16'h4000, 32'h1111_2222, "R4 wr lo 0");
        acc(1, 16'h4001, 32'hFFFF_FF3C, "R4 wr hi 0");
        acc(1, 16'h47FE, 32'hDEAD_BEEF, "R4 wr lo last");
        acc(1, 16'h47FF, 32'h0000_0081, "R4 wr hi last");
        acc(0, 16'h4000, 0, "R4 rd lo 0");
        acc(0, 16'h4001, 0, "R4 rd hi 0");
        acc(0, 16'h47FE, 0, "R4 rd lo last");
        acc(0, 16'h47FF, 0, "R4 rd hi last");
        // R5 control word readback, R9 unmapped addresses
        acc(0, 16'h0000, 0, "R5 ctrl rd");
        acc(1, 16'h0004, 32'hFFFF_FFFF, "R9 wr unmapped");
        acc(0, 16'h0004, 0, "R9 rd unmapped");
        acc(0, 16'h0000, 0, "R9 ctrl unchanged");
        // R5/R6 enter run mode
        acc(1, 16'h0000, 32'h1, "R6 enter run");
        acc(0, 16'h0000, 0, "R5 ctrl rd run");
        // R7 blocked inner space
        acc(0, 16'h8003, 0, "R7 rd blocked");
        acc(1, 16'h8003, 32'h7777_7777, "R7 wr blocked");
        acc(0, 16'h0000, 0, "R7 err visible");
        acc(1, 16'h4000, 32'h3333_4444, "R8 shared wr run");
        acc(0, 16'h4000, 0, "R8 shared rd run");
        acc(0, 16'h0000, 0, "R7 err sticky");
        acc(1, 16'h0000, 32'h3, "R5 clear err stay run");
        acc(0, 16'h0000, 0, "R5 ctrl after clear");
        // R10 coprocessor port in run mode
        core_op(0, 10'd0, 0, "R10 core rd host data");
        core_op(1, 10'd7, 40'hC1_2345_6789, "R10 core wr");
        acc(0, 16'h400E, 0, "R10 host sees core lo");
        acc(0, 16'h400F, 0, "R10 host sees core hi");
        core_op(0, 10'd1023, 0, "R10 core rd last");
        // R11 same-edge collision: host high half vs core full word
        @(negedge clk);
        hsel = 1; hwen = 1; haddr = 16'h400B; hwdata = 32'h0000_00EE;
        @(posedge clk);
        m_busy = 1;
        @(negedge clk);
        core_en = 1; core_wen = 1; core_addr = 10'd5; core_wdata = 40'h5A_0102_0304;
        @(posedge clk);
        m_busy = 0;
        model_wr(16'h400B, 32'h0000_00EE);
        m_sh[5] = 40'h5A_0102_0304;
        @(negedge clk);
        hsel = 0; hwen = 0; core_en = 0; core_wen = 0;
        acc(0, 16'h400B, 0, "R11 collision hi");
        acc(0, 16'h400A, 0, "R11 collision lo");
        // back to system mode: dropped write left the word untouched
        acc(1, 16'h0000, 32'h0, "R6 leave run");
        acc(0, 16'h8003, 0, "R7 dropped write");
        acc(1, 16'h8010, 32'h0000_0055, "R3 wr after run");
        acc(0, 16'h8010, 0, "R3 rd after run");
        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule